// File: doc/BRIEF.md
# Keyed User Interrupt Threshold Gate

This block keeps a 32-bit control word whose only live field is a 4-bit user interrupt threshold. It uses that threshold to decide which pending maskable interrupt requests may reach the processor. Each request source carries a valid bit, a 4-bit priority level and a per-source disable bit. A request qualifies when it is enabled and its level is strictly above both the user threshold and the processor's status-register mask level. Among the qualifying requests, the one with the highest level wins, and on equal levels the lowest source index wins. A non-maskable request ignores all of this and always wins.

The control word sits behind a simple select/write strobe port. A write changes the threshold only when the top byte of the write data carries the unlock key 0xA5. Any other write is dropped without effect. Software running in user mode may access the word, so the protection depends only on the key. The accept decision is registered, and it appears one clock after the inputs that caused it.

Top module: `user_thresh_gate`

## Requirements
- R1: After reset the threshold is 0, a read returns 0x00000000 and no accept is signalled.
- R2: A write (reg_sel=1, reg_wr=1) with wdata[31:24]=0xA5 loads the threshold from wdata[7:4], and the new value takes effect from the next clock edge.
- R3: A write whose wdata[31:24] is not 0xA5 leaves the threshold unchanged.
- R4: A read (reg_sel=1, reg_wr=0) returns the threshold in rdata[7:4] with every other bit zero, including the key byte. Reading does not alter the threshold.
- R5: A request whose level is less than or equal to the threshold is not accepted. A request whose level is greater than the threshold can be accepted.
- R6: With a threshold of 0xF no maskable request is accepted.
- R7: A request whose per-source disable bit is 1 is not accepted.
- R8: A request is accepted only if its level is strictly greater than sr_lvl.
- R9: Among the qualifying requests the highest level wins, and ties go to the lowest source index. acc_lvl and acc_src report the winner.
- R10: nmi=1 always gives acc_valid=1, acc_nmi=1, acc_lvl=0xF and acc_src=0, whatever the threshold, the disable bits, sr_lvl or the other requests.
- R11: The accept outputs change only at a clock edge, one cycle after the inputs that produce them. When nothing qualifies, acc_valid=0, acc_nmi=0, acc_lvl=0 and acc_src=0.
- R12: Accepting interrupts never changes the stored threshold.
- R13: With the default build, writes and reads made with user_mode=1 behave exactly like those made with user_mode=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_sel | input | 1 | Address decode strobe for the control word |
| reg_wr | input | 1 | 1 = write, 0 = read while selected |
| user_mode | input | 1 | Access comes from user mode |
| wdata | input | 32 | Write data, key in [31:24], threshold in [7:4] |
| rdata | output | 32 | Read data, valid while selected for read |
| irq_req | input | 8 | Per-source request valid |
| irq_lvl | input | 32 | Per-source 4-bit level, source i at [4i+3:4i] |
| irq_mask | input | 8 | Per-source disable bit, 1 = blocked |
| sr_lvl | input | 4 | Status-register mask level |
| nmi | input | 1 | Non-maskable request |
| acc_valid | output | 1 | Registered accept |
| acc_nmi | output | 1 | Registered: the accept is the non-maskable one |
| acc_lvl | output | 4 | Registered level of the winner |
| acc_src | output | 3 | Registered index of the winner |

## Verification
The bench uses the defaults: eight sources, 4-bit levels, the 0xA5 key in the top byte, and user-mode access allowed. With eight sources it can place equal-level requests at separated indices to check tie-breaking. The 4-bit level makes the all-ones threshold boundary reachable in a few writes. Because user access is enabled, the bench can show that user_mode has no effect on the control word.

// File: rtl/utg_pkg.sv
package utg_pkg;
   localparam int unsigned UTG_KEY_W   = 8;
   localparam logic [7:0]  UTG_KEY_DEF = 8'hA5;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/utg_thresh_reg.sv
module utg_thresh_reg
   import utg_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LVL_W      = 4,
   parameter int unsigned KEY_W      = UTG_KEY_W,
   parameter logic [KEY_W-1:0] KEY   = UTG_KEY_DEF,
   parameter int unsigned THR_LSB    = 4,
   parameter bit          ALLOW_USER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic              user_mode,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [LVL_W-1:0]  thr
);
   localparam int unsigned KEY_LSB = DATA_W - KEY_W;

   if (THR_LSB + LVL_W > KEY_LSB) begin : g_bad_layout
      $error("threshold field overlaps key byte");
   end

   logic      mode_ok;
   acc_kind_e kind;
   logic      key_hit;
   logic [LVL_W-1:0] thr_q;

   if (ALLOW_USER) begin : g_user_ok
      assign mode_ok = 1'b1;
   end else begin : g_priv_only
      assign mode_ok = ~user_mode;
   end

   always_comb begin
      kind = ACC_NONE;
      if (reg_sel && mode_ok) begin
         kind = reg_wr ? ACC_WRITE : ACC_READ;
      end
   end

   assign key_hit = (wdata[KEY_LSB +: KEY_W] == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q <= '0;
      end else if (kind == ACC_WRITE && key_hit) begin
         thr_q <= wdata[THR_LSB +: LVL_W];
      end
   end

   always_comb begin
      rdata = '0;
      if (kind == ACC_READ) begin
         rdata[THR_LSB +: LVL_W] = thr_q;
      end
   end

   assign thr = thr_q;

   // R3
   key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && reg_wr && wdata[KEY_LSB +: KEY_W] != KEY) |=> $stable(thr_q));

   // R12
   thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_sel && reg_wr) |=> $stable(thr_q));

   // R4
   read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[DATA_W-1:THR_LSB+LVL_W] == '0));
endmodule

// File: rtl/utg_qualify.sv
module utg_qualify #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned LVL_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SRC-1:0]       req,
   input  logic [N_SRC*LVL_W-1:0] lvl,
   input  logic [N_SRC-1:0]       dis,
   input  logic [LVL_W-1:0]       thr,
   input  logic [LVL_W-1:0]       sr_lvl,
   output logic [N_SRC-1:0]       qual
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic [LVL_W-1:0] l;
      assign l       = lvl[i*LVL_W +: LVL_W];
      assign qual[i] = req[i] & ~dis[i] & (l > thr) & (l > sr_lvl);
   end

   // R6
   full_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr == '1) |-> (qual == '0));
endmodule

// File: rtl/utg_pick.sv
module utg_pick #(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned LVL_W = 4,
   parameter int unsigned SRC_W = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_SRC-1:0]       qual,
   input  logic [N_SRC*LVL_W-1:0] lvl,
   input  logic                   nmi,
   output logic                   acc_valid,
   output logic                   acc_nmi,
   output logic [LVL_W-1:0]       acc_lvl,
   output logic [SRC_W-1:0]       acc_src
);
   logic             found;
   logic [LVL_W-1:0] best_lvl;
   logic [SRC_W-1:0] best_src;

   always_comb begin
      found    = 1'b0;
      best_lvl = '0;
      best_src = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (qual[i] && (!found || lvl[i*LVL_W +: LVL_W] > best_lvl)) begin
            found    = 1'b1;
            best_lvl = lvl[i*LVL_W +: LVL_W];
            best_src = SRC_W'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_nmi   <= 1'b0;
         acc_lvl   <= '0;
         acc_src   <= '0;
      end else if (nmi) begin
         acc_valid <= 1'b1;
         acc_nmi   <= 1'b1;
         acc_lvl   <= '1;
         acc_src   <= '0;
      end else begin
         acc_valid <= found;
         acc_nmi   <= 1'b0;
         acc_lvl   <= best_lvl;
         acc_src   <= best_src;
      end
   end

   // R10
   nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> (acc_valid && acc_nmi && acc_lvl == '1));

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nmi && qual == '0) |=> (!acc_valid && acc_lvl == '0 && acc_src == '0));
endmodule

// File: rtl/user_thresh_gate.sv
module user_thresh_gate
   import utg_pkg::*;
#(
   parameter int unsigned N_SRC      = 8,
   parameter int unsigned LVL_W      = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned THR_LSB    = 4,
   parameter logic [7:0]  KEY        = UTG_KEY_DEF,
   parameter bit          ALLOW_USER = 1'b1,
   localparam int unsigned SRC_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_sel,
   input  logic                   reg_wr,
   input  logic                   user_mode,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   input  logic [N_SRC-1:0]       irq_req,
   input  logic [N_SRC*LVL_W-1:0] irq_lvl,
   input  logic [N_SRC-1:0]       irq_mask,
   input  logic [LVL_W-1:0]       sr_lvl,
   input  logic                   nmi,
   output logic                   acc_valid,
   output logic                   acc_nmi,
   output logic [LVL_W-1:0]       acc_lvl,
   output logic [SRC_W-1:0]       acc_src
);
   if (N_SRC < 2) begin : g_bad_nsrc
      $error("at least two sources required");
   end
   if (LVL_W < 2) begin : g_bad_lvl
      $error("level width too small");
   end

   logic [LVL_W-1:0] thr;
   logic [N_SRC-1:0] qual;

   utg_thresh_reg #(
      .DATA_W(DATA_W), .LVL_W(LVL_W), .KEY_W(UTG_KEY_W), .KEY(KEY),
      .THR_LSB(THR_LSB), .ALLOW_USER(ALLOW_USER)
   ) u_reg (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .user_mode(user_mode), .wdata(wdata), .rdata(rdata), .thr(thr)
   );

   utg_qualify #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_qual (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .lvl(irq_lvl),
      .dis(irq_mask), .thr(thr), .sr_lvl(sr_lvl), .qual(qual)
   );

   utg_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W), .SRC_W(SRC_W)) u_pick (
      .clk(clk), .rst_n(rst_n), .qual(qual), .lvl(irq_lvl), .nmi(nmi),
      .acc_valid(acc_valid), .acc_nmi(acc_nmi), .acc_lvl(acc_lvl),
      .acc_src(acc_src)
   );

   // R5 R8
   above_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_nmi) |-> (acc_lvl > $past(thr) && acc_lvl > $past(sr_lvl)));
endmodule

// File: tb/user_thresh_gate_bench.sv
module user_thresh_gate_bench;
   localparam int N = 8;
   localparam int LW = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic reg_sel = 0, reg_wr = 0, user_mode = 0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [N-1:0] irq_req = '0, irq_mask = '0;
   logic [N*LW-1:0] irq_lvl = '0;
   logic [LW-1:0] sr_lvl = '0;
   logic nmi = 0;
   logic acc_valid, acc_nmi;
   logic [LW-1:0] acc_lvl;
   logic [2:0] acc_src;

   int checks = 0, errors = 0, cyc = 0;
   logic [3:0] model_thr = '0;
   logic [8:0] exp_q[$];
   int due_q[$];
   string tag_q[$];
   logic wd_fail = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   user_thresh_gate u_user_thresh_gate (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .user_mode(user_mode), .wdata(wdata), .rdata(rdata),
      .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_mask(irq_mask),
      .sr_lvl(sr_lvl), .nmi(nmi), .acc_valid(acc_valid), .acc_nmi(acc_nmi),
      .acc_lvl(acc_lvl), .acc_src(acc_src)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [8:0] expect_of(input logic [N-1:0] rq, input logic [N*LW-1:0] lv,
                                           input logic [N-1:0] mk, input logic [3:0] sr,
                                           input logic nm, input logic [3:0] th);
      logic v; logic [3:0] bl; logic [2:0] bs;
      if (nm) return {1'b1, 1'b1, 4'hF, 3'd0};
      v = 0; bl = 0; bs = 0;
      for (int i = 0; i < N; i++) begin
         logic [3:0] l;
         l = lv[i*LW +: LW];
         if (rq[i] && !mk[i] && l > th && l > sr && (!v || l > bl)) begin
            v = 1; bl = l; bs = 3'(i);
         end
      end
      return {v, 1'b0, bl, bs};
   endfunction

   // drive one cycle of interrupt inputs (at negedge) and queue the expected result
   task automatic step(input logic [N-1:0] rq, input logic [N*LW-1:0] lv, input logic [N-1:0] mk,
                       input logic [3:0] sr, input logic nm, input string tag);
      irq_req = rq; irq_lvl = lv; irq_mask = mk; sr_lvl = sr; nmi = nm;
      exp_q.push_back(expect_of(rq, lv, mk, sr, nm, model_thr));
      due_q.push_back(cyc + 1);
      tag_q.push_back(tag);
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      step('0, '0, '0, '0, 1'b0, tag);
   endtask

   task automatic wr(input logic [31:0] d, input logic um, input string tag);
      reg_sel = 1; reg_wr = 1; wdata = d; user_mode = um;
      if (d[31:24] == 8'hA5) model_thr = d[7:4];
      idle(tag);
      reg_sel = 0; reg_wr = 0; wdata = '0; user_mode = 0;
   endtask

   task automatic rd(input logic um, input string tag);
      logic [31:0] e;
      reg_sel = 1; reg_wr = 0; user_mode = um;
      #1;
      e = {24'h0, model_thr, 4'h0};
      chk(rdata === e, tag, rdata, e);
      @(negedge clk);
      reg_sel = 0; user_mode = 0;
   endtask

   function automatic logic [N*LW-1:0] lv1(input int s, input logic [3:0] l);
      logic [N*LW-1:0] r = '0;
      r[s*LW +: LW] = l;
      return r;
   endfunction

   // monitor: compare registered outputs when due
   always @(negedge clk) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
         logic [8:0] e, a;
         string t;
         e = exp_q.pop_front(); void'(due_q.pop_front()); t = tag_q.pop_front();
         a = {acc_valid, acc_nmi, acc_lvl, acc_src};
         chk(a === e, t, 32'(a), 32'(e));
      end
   end

   initial begin
      #200000;
      wd_fail = 1;
   end

   initial begin
      logic [N*LW-1:0] lv;
      fork
         begin : main
            @(negedge clk); @(negedge clk);
            // R1 reset state
            chk(acc_valid === 0 && acc_lvl === 0, "R1 outputs in reset", 32'(acc_valid), 0);
            rst_n = 1;
            @(negedge clk);
            rd(0, "R1 read after reset");
            idle("R1 idle after reset");
            // R11 basic accept, and not visible before the edge
            irq_req = 8'h01; irq_lvl = lv1(0, 4'd3);
            #1 chk(acc_valid === 0, "R11 no combinational path", 32'(acc_valid), 0);
            step(8'h01, lv1(0, 4'd3), '0, 0, 0, "R11 accept one cycle later");
            idle("R11 idle clears");
            // R3 bad key
            wr(32'h5A00_0050, 0, "R3 bad key write");
            rd(0, "R3 threshold unchanged");
            // R2 R4 good key with junk bits
            wr(32'hA5FF_FF5F, 0, "R2 keyed write");
            rd(0, "R2 R4 read format");
            rd(0, "R4 second read same");
            // R5 boundary
            step(8'h04, lv1(2, 4'd5), '0, 0, 0, "R5 level equal threshold masked");
            step(8'h04, lv1(2, 4'd4), '0, 0, 0, "R5 level below threshold masked");
            step(8'h04, lv1(2, 4'd6), '0, 0, 0, "R5 level above threshold accepted");
            // R7 disable bit
            step(8'h04, lv1(2, 4'd9), 8'h04, 0, 0, "R7 disabled source blocked");
            step(8'h04, lv1(2, 4'd9), 8'hFB, 0, 0, "R7 other disables ignored");
            // R8 status level
            step(8'h02, lv1(1, 4'd7), '0, 4'd7, 0, "R8 equal to sr blocked");
            step(8'h02, lv1(1, 4'd8), '0, 4'd7, 0, "R8 above sr accepted");
            // R9 arbitration
            lv = lv1(1, 4'd9) | lv1(3, 4'd12) | lv1(5, 4'd12) | lv1(7, 4'd14);
            step(8'h2A, lv, '0, 0, 0, "R9 tie lowest index");
            step(8'hAA, lv, '0, 0, 0, "R9 highest level wins");
            step(8'hAA, lv, 8'h80, 0, 0, "R9 masked top falls back");
            // R10 nmi
            step(8'hAA, lv, '0, 4'hF, 1, "R10 nmi overrides");
            idle("R10 nmi released");
            // R12 accepts do not touch threshold
            rd(0, "R12 threshold after accepts");
            // R6 all-ones threshold, written from user mode (R13)
            wr(32'hA500_00F0, 1, "R13 user write");
            rd(1, "R13 user read");
            step(8'hFF, {8{4'hF}}, '0, 0, 0, "R6 full threshold masks all");
            step(8'hFF, {8{4'hF}}, '0, 0, 1, "R6 R10 nmi still accepted");
            wr(32'hA400_0000, 1, "R3 near-key ignored");
            rd(0, "R3 threshold still F");
            wr(32'hA500_0000, 0, "R2 clear threshold");
            step(8'h01, lv1(0, 4'd1), '0, 0, 0, "R2 new threshold in effect");
            idle("R11 final idle");
            @(negedge clk);
         end
         begin : dog
            wait (wd_fail);
            chk(0, "watchdog", 0, 1);
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule